// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block decides whether the supply rail feeding battery-backed RAM is taken from the main supply or from the backup cell. It also drives an active-low power-fail warning. Its inputs are comparator flags that are already synchronous to the clock and already carry their hysteresis: main supply under the switch threshold, main supply under the battery voltage, main supply under the absolute floor, main supply over the reset threshold, and power-fail input under its reference.

Entry into backup needs two conditions together: the main supply must be under the switch threshold and also under the battery. Because of this, a battery that is higher than a healthy main supply never takes over. The floor flag forces backup on its own. The return to the main supply waits until the main supply clears the reset threshold, which is higher than the entry threshold. Selection is a registered two-state machine. It wakes from reset on the battery and leaves it only when a sample shows the main supply healthy.

Top module: `supsw_ctrl`

## Requirements
- R1: While reset is held and at the first sample after it, battery is selected (sel_batt_o = 1, backup_o = 1) and pfail_n_o is 0.
- R2: From main mode, a sample with below_sw_i = 1 and below_batt_i = 1 selects the battery one clock later.
- R3: A sample with below_floor_i = 1 selects or keeps the battery one clock later. This holds whatever the other flags are, including above_rst_i = 1.
- R4: In main mode, while below_sw_i = 0 and below_floor_i = 0, the main supply stays selected even when below_batt_i = 1.
- R5: In main mode, with below_sw_i = 1 and below_batt_i = 0 (and no floor), the main supply stays selected.
- R6: In backup mode, the main supply is selected again one clock after a sample with above_rst_i = 1 and below_floor_i = 0, whatever below_batt_i is. With above_rst_i = 0 the battery stays selected, even when below_sw_i = 0.
- R7: One clock after a sample with pfi_low_i = 1 or below_sw_i = 1, pfail_n_o is 0. In main mode with both flags 0, pfail_n_o is 1.
- R8: pfail_n_o is 0 in every cycle in which the battery is selected, whatever pfi_low_i is.
- R9: backup_o always equals sel_batt_o. Both outputs change exactly one clock after the deciding sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| below_sw_i | input | 1 | Main supply under switch threshold |
| below_batt_i | input | 1 | Main supply under battery voltage |
| below_floor_i | input | 1 | Main supply under absolute floor |
| above_rst_i | input | 1 | Main supply over reset threshold |
| pfi_low_i | input | 1 | Power-fail input under its reference |
| sel_batt_o | output | 1 | 1 = RAM rail from battery |
| backup_o | output | 1 | Backup-mode status |
| pfail_n_o | output | 1 | Active-low power-fail output |

## Verification
A wrong internal mode shows at the ports within one clock. sel_batt_o and backup_o are the state itself. A stuck or wrong state also pins pfail_n_o low while main mode should let it rise. The dangerous faults are an entry taken while the main supply is above the switch threshold, and an exit taken early at the entry threshold. Both show on sel_batt_o at the first sample after the flags that trigger them. The bench therefore walks each flag combination against both modes and checks the cycle right after it.

// File: rtl/supsw_pkg.sv
package supsw_pkg;
  typedef enum logic {SRC_MAIN = 1'b0, SRC_BATT = 1'b1} src_e;

  // Conditions that pull the rail onto the battery
  function automatic logic need_batt(input logic b_sw, input logic b_bat,
                                     input logic b_floor);
    return b_floor | (b_sw & b_bat);
  endfunction

  // Condition that allows the rail to return to main supply
  function automatic logic may_return(input logic a_rst, input logic b_floor);
    return a_rst & ~b_floor;
  endfunction

  // Power-fail warning active when either low condition holds or in backup
  function automatic logic warn_on(input logic pfi_lo, input logic b_sw,
                                   input logic in_batt);
    return pfi_lo | b_sw | in_batt;
  endfunction
endpackage

// File: rtl/supsw_sel_fsm.sv
module supsw_sel_fsm
  import supsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic b_sw,
  input  logic b_bat,
  input  logic b_floor,
  input  logic a_rst,
  output src_e src_q,
  output src_e src_d,
  output logic enter_ev,
  output logic exit_ev
);
  always_comb begin
    enter_ev = 1'b0;
    exit_ev  = 1'b0;
    src_d    = src_q;
    unique case (src_q)
      SRC_MAIN: if (need_batt(b_sw, b_bat, b_floor)) begin
        enter_ev = 1'b1;
        src_d    = SRC_BATT;
      end
      SRC_BATT: if (may_return(a_rst, b_floor)) begin
        exit_ev = 1'b1;
        src_d   = SRC_MAIN;
      end
      default: src_d = SRC_BATT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= SRC_BATT;
    else        src_q <= src_d;
  end
endmodule

// File: rtl/supsw_pfail_gen.sv
module supsw_pfail_gen
  import supsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pfi_lo,
  input  logic b_sw,
  input  src_e src_d,
  output logic pfail_n_q
);
  logic warn_d;
  assign warn_d = warn_on(pfi_lo, b_sw, src_d == SRC_BATT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pfail_n_q <= 1'b0;
    else        pfail_n_q <= ~warn_d;
  end
endmodule

// File: rtl/supsw_ctrl.sv
module supsw_ctrl
  import supsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic below_sw_i,
  input  logic below_batt_i,
  input  logic below_floor_i,
  input  logic above_rst_i,
  input  logic pfi_low_i,
  output logic sel_batt_o,
  output logic backup_o,
  output logic pfail_n_o
);
  src_e src_q;
  src_e src_d;
  logic enter_ev;
  logic exit_ev;

  supsw_sel_fsm fsm_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .b_sw    (below_sw_i),
    .b_bat   (below_batt_i),
    .b_floor (below_floor_i),
    .a_rst   (above_rst_i),
    .src_q   (src_q),
    .src_d   (src_d),
    .enter_ev(enter_ev),
    .exit_ev (exit_ev)
  );

  supsw_pfail_gen pf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pfi_lo   (pfi_low_i),
    .b_sw     (below_sw_i),
    .src_d    (src_d),
    .pfail_n_q(pfail_n_o)
  );

  assign sel_batt_o = (src_q == SRC_BATT);
  assign backup_o   = (src_q == SRC_BATT);
endmodule

// File: rtl/supsw_ctrl_chk.sv
module supsw_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic below_sw_i,
  input logic below_batt_i,
  input logic below_floor_i,
  input logic above_rst_i,
  input logic pfi_low_i,
  input logic sel_batt_o,
  input logic backup_o,
  input logic pfail_n_o,
  input logic enter_ev,
  input logic exit_ev
);
  a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_batt_o && below_sw_i && below_batt_i) |=> sel_batt_o);
  a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
    below_floor_i |=> sel_batt_o);
  a_r4_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_batt_o && !below_floor_i && !(below_sw_i && below_batt_i)) |=> !sel_batt_o);
  a_r6_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_batt_o && above_rst_i && !below_floor_i) |=> !sel_batt_o);
  a_r6_stay: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_batt_o && !above_rst_i) |=> sel_batt_o);
  a_r7_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pfi_low_i || below_sw_i) |=> !pfail_n_o);
  a_r7_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfi_low_i && !below_sw_i && !below_floor_i && !sel_batt_o) |=> pfail_n_o);
  a_r8_forced: assert property (@(posedge clk) disable iff (!rst_n)
    sel_batt_o |-> !pfail_n_o);
  a_r9_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    backup_o == sel_batt_o);
  a_r9_events: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enter_ev, exit_ev}));
  a_r9_enter_ev: assert property (@(posedge clk) disable iff (!rst_n)
    enter_ev |=> sel_batt_o);
endmodule

bind supsw_ctrl supsw_ctrl_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .below_sw_i   (below_sw_i),
  .below_batt_i (below_batt_i),
  .below_floor_i(below_floor_i),
  .above_rst_i  (above_rst_i),
  .pfi_low_i    (pfi_low_i),
  .sel_batt_o   (sel_batt_o),
  .backup_o     (backup_o),
  .pfail_n_o    (pfail_n_o),
  .enter_ev     (enter_ev),
  .exit_ev      (exit_ev)
);

// File: tb/supsw_ctrl_tb_top.sv
module supsw_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic below_sw_i = 1'b0, below_batt_i = 1'b0, below_floor_i = 1'b0;
  logic above_rst_i = 1'b1, pfi_low_i = 1'b0;
  logic sel_batt_o, backup_o, pfail_n_o;
  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  supsw_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .below_sw_i(below_sw_i), .below_batt_i(below_batt_i),
    .below_floor_i(below_floor_i), .above_rst_i(above_rst_i),
    .pfi_low_i(pfi_low_i),
    .sel_batt_o(sel_batt_o), .backup_o(backup_o), .pfail_n_o(pfail_n_o)
  );

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  task automatic check(string req, logic exp_sel, logic exp_pfn);
    n_run++;
    if (sel_batt_o !== exp_sel || backup_o !== exp_sel || pfail_n_o !== exp_pfn) begin
      n_fail++;
      $display("FAIL %s: actual sel=%b bk=%b pfn=%b expected sel=%b bk=%b pfn=%b",
               req, sel_batt_o, backup_o, pfail_n_o, exp_sel, exp_sel, exp_pfn);
    end
  endtask

  // Drive flags at a falling edge, check at the next falling edge
  task automatic step(logic bsw, logic bbat, logic bfl, logic arst, logic pfi,
                      string req, logic exp_sel, logic exp_pfn);
    below_sw_i = bsw; below_batt_i = bbat; below_floor_i = bfl;
    above_rst_i = arst; pfi_low_i = pfi;
    @(negedge clk);
    check(req, exp_sel, exp_pfn);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b1, 1'b0);
    rst_n = 1'b1;
    below_sw_i = 1'b1; below_batt_i = 1'b0; above_rst_i = 1'b0;
    @(negedge clk);
    check("R1 first sample", 1'b1, 1'b0);
    step(0, 0, 0, 1, 0, "R6 exit after reset", 1'b0, 1'b1);
  endtask

  task automatic t_battery_higher();
    step(0, 1, 0, 0, 0, "R4 batt above main", 1'b0, 1'b1);
    step(0, 1, 0, 1, 0, "R4 batt above main hold", 1'b0, 1'b1);
  endtask

  task automatic t_between_thresholds();
    step(1, 0, 0, 0, 0, "R5 under sw above batt", 1'b0, 1'b0);
    step(1, 0, 0, 0, 0, "R7 sw warn main", 1'b0, 1'b0);
    step(1, 1, 0, 0, 0, "R2 enter", 1'b1, 1'b0);
  endtask

  task automatic t_deferred_exit();
    step(0, 0, 0, 0, 0, "R6 above sw no exit", 1'b1, 1'b0);
    step(0, 0, 0, 0, 0, "R8 backup forces low", 1'b1, 1'b0);
    step(0, 1, 0, 1, 0, "R6 exit indep of batt", 1'b0, 1'b1);
  endtask

  task automatic t_floor();
    step(0, 0, 1, 1, 0, "R3 floor forces entry", 1'b1, 1'b0);
    step(0, 0, 1, 1, 0, "R3 floor beats reset thr", 1'b1, 1'b0);
    step(0, 0, 0, 1, 0, "R6 exit after floor", 1'b0, 1'b1);
  endtask

  task automatic t_pfail();
    step(0, 0, 0, 1, 1, "R7 pfi low", 1'b0, 1'b0);
    step(0, 0, 0, 1, 0, "R7 pfi clear", 1'b0, 1'b1);
    step(1, 1, 0, 0, 0, "R2 enter again", 1'b1, 1'b0);
    step(0, 0, 0, 0, 0, "R8 pfi clear in backup", 1'b1, 1'b0);
    step(0, 0, 0, 1, 1, "R9 exit with pfi low", 1'b0, 1'b0);
    step(0, 0, 0, 1, 0, "R9 settle main", 1'b0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_battery_higher();
    t_between_thresholds();
    t_deferred_exit();
    t_floor();
    t_pfail();
    finish_run();
  end
endmodule